// File: doc/BRIEF.md
# Multirate FIR Bank Selector

This block runs three copies of one symmetric low-pass FIR datapath from a single fast clock. Each copy advances at its own effective sample rate, and one of their outputs goes on to a converter. The fast copy takes a new sample on every clock. The middle copy is enabled one clock in `DIV_MID`, and the slow copy one clock in `DIV_SLOW`. With an 80 MHz clock and the default dividers, the three rates are 80 MHz, 10 MHz and 2.5 MHz. The enables come from one shared free-running counter, so every slow strobe coincides with a middle strobe.

Each copy has its own tap line. It captures the shared input word only on its own enable, and it holds its registered result between enables. The selected output is therefore a zero-order hold at that copy's rate. There is no decimating pre-filter ahead of the slower copies. Tones above half a slow rate fold back (alias) in that copy's output, and this is intended. A two-bit switch input is synchronised into the clock domain. It then picks which copy drives the registered output, and it can be changed at any time while the block runs.

Top module: `fir_rate_bank`

## Requirements
- R1: While reset is low, `dout` reads zero, the strobe counter is cleared, and every copy's tap line and result are cleared; the selection returns to the fast copy.
- R2: With the fast copy selected, `dout` two clock edges after a sample is applied equals sum over k of c_k·x[n−k], where x[n] is that sample and earlier samples are taken on every edge.
- R3: The middle copy is enabled on edge number k after reset release exactly when k is a multiple of `DIV_MID` (first at edge `DIV_MID`), i.e. one clock in every `DIV_MID`.
- R4: The slow copy is enabled on edge k exactly when k is a multiple of `DIV_SLOW`, and every slow enable falls on a middle enable.
- R5: Switch code 2'b00 and 2'b11 select the fast copy, 2'b01 the middle copy and 2'b10 the slow copy; the switch passes through two flops, so a new code set before edge t shows its copy in `dout` after edge t+2.
- R6: A slower copy samples `din` only on its enable edge and keeps its result unchanged on all other edges (zero-order hold at its rate).
- R7: A slower copy applies the FIR to the decimated sample sequence with no band-limiting, so a tone at the fast Nyquist rate (alternating ±A) decimated by an even factor appears as a constant, aliased level.
- R8: The coefficients are symmetric, c_k = min(k, TAPS−1−k) + 1 (1,2,3,2,1 for five taps), visible as the impulse response of any copy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sample clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | DW (12) | Signed input sample shared by all copies |
| sw | input | 2 | Asynchronous rate-select switches |
| dout | output | DW+CW+clog2(TAPS) (23) | Signed registered output of the selected copy |

## Verification
Every switch code is tried against four input patterns. An impulse exposes the coefficient order and symmetry, and shows whether each copy captured it on or off its strobe. A step separates the hold behaviour from the settling of the taps. An alternating full-swing tone at the fast Nyquist rate must collapse into a constant aliased level on the decimated copies, so it separates a correct strobe phase from a wrong one and reveals any smoothing. Pseudo-random data and a phase that changes the switches every three clocks test the arithmetic in general, the two-flop selection latency and the mapping of code 2'b11.

// File: rtl/fir_rate_bank_pkg.sv
package fir_rate_bank_pkg;

   localparam int NPATH = 3;

   typedef enum logic [1:0] {
      PATH_FAST = 2'd0,
      PATH_MID  = 2'd1,
      PATH_SLOW = 2'd2
   } path_e;

   // Symmetric triangular tap weight: rises by one up to the centre tap.
   function automatic int coef_at(input int k, input int taps);
      int m;
      m = (k < taps - 1 - k) ? k : taps - 1 - k;
      return m + 1;
   endfunction

   // Switch code to copy index; the unused code falls back to the fast copy.
   function automatic path_e decode_sel(input logic [1:0] code);
      case (code)
         2'b01:   return PATH_MID;
         2'b10:   return PATH_SLOW;
         default: return PATH_FAST;
      endcase
   endfunction

endpackage

// File: rtl/fir_rate_bank_strobe.sv
module fir_rate_bank_strobe #(
   parameter int DIV_MID  = 8,
   parameter int DIV_SLOW = 32
) (
   input  logic clk,
   input  logic rst_n,
   output logic stb_mid,
   output logic stb_slow
);

   localparam int CNT_W = $clog2(DIV_SLOW);
   localparam int MID_W = $clog2(DIV_MID);

   if ((1 << MID_W) != DIV_MID) begin : g_bad_mid
      $error("DIV_MID must be a power of two");
   end
   if ((1 << CNT_W) != DIV_SLOW) begin : g_bad_slow
      $error("DIV_SLOW must be a power of two");
   end
   if (DIV_MID < 2 || DIV_SLOW <= DIV_MID) begin : g_bad_order
      $error("dividers must satisfy 2 <= DIV_MID < DIV_SLOW");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + CNT_W'(1);
   end

   // Both strobes decode the same counter, so the slow one lands on a mid one.
   assign stb_mid  = &cnt_q[MID_W-1:0];
   assign stb_slow = &cnt_q;

endmodule

// File: rtl/fir_rate_bank_sync.sv
module fir_rate_bank_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("synchroniser needs at least two stages");
   end

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      end else begin
         stg_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/fir_rate_bank_path.sv
module fir_rate_bank_path
   import fir_rate_bank_pkg::*;
#(
   parameter int DW   = 12,
   parameter int CW   = 8,
   parameter int TAPS = 5,
   parameter bit FOLD = 1'b1,
   parameter int OW   = DW + CW + $clog2(TAPS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic signed [DW-1:0] x,
   output logic signed [OW-1:0] y
);

   localparam int MID   = TAPS / 2;
   localparam int NTERM = FOLD ? MID + 1 : TAPS;

   if (TAPS < 3 || (TAPS % 2) == 0) begin : g_bad_taps
      $error("TAPS must be odd and at least 3");
   end
   if (coef_at(MID, TAPS) >= (1 << (CW - 1))) begin : g_bad_cw
      $error("CW too narrow for the centre coefficient");
   end
   if (OW < DW + CW + 2) begin : g_bad_ow
      $error("OW too narrow for the accumulated sum");
   end

   logic signed [DW-1:0] tap_q [TAPS-1];
   logic signed [DW-1:0] win   [TAPS];
   logic signed [OW-1:0] term  [NTERM];
   logic signed [OW-1:0] acc;
   logic signed [OW-1:0] y_q;

   // Window seen on an enable edge: new sample followed by the held taps.
   always_comb begin
      win[0] = x;
      for (int i = 1; i < TAPS; i++) win[i] = tap_q[i-1];
   end

   if (FOLD) begin : g_fold
      for (genvar g = 0; g < MID; g++) begin : g_pair
         localparam logic signed [CW-1:0] C = CW'(coef_at(g, TAPS));
         logic signed [DW:0]    pre;
         logic signed [DW+CW:0] prd;
         assign pre     = (DW+1)'(win[g]) + (DW+1)'(win[TAPS-1-g]);
         assign prd     = (DW+CW+1)'(pre) * (DW+CW+1)'(C);
         assign term[g] = OW'(prd);
      end
      begin : g_centre
         localparam logic signed [CW-1:0] CM = CW'(coef_at(MID, TAPS));
         logic signed [DW+CW-1:0] prd_m;
         assign prd_m     = (DW+CW)'(win[MID]) * (DW+CW)'(CM);
         assign term[MID] = OW'(prd_m);
      end
   end else begin : g_direct
      for (genvar g = 0; g < TAPS; g++) begin : g_tap
         localparam logic signed [CW-1:0] C = CW'(coef_at(g, TAPS));
         logic signed [DW+CW-1:0] prd;
         assign prd     = (DW+CW)'(win[g]) * (DW+CW)'(C);
         assign term[g] = OW'(prd);
      end
   end

   always_comb begin
      acc = '0;
      for (int i = 0; i < NTERM; i++) acc = acc + term[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < TAPS - 1; i++) tap_q[i] <= '0;
         y_q <= '0;
      end else if (en) begin
         tap_q[0] <= x;
         for (int i = 1; i < TAPS - 1; i++) tap_q[i] <= tap_q[i-1];
         y_q <= acc;
      end
   end

   assign y = y_q;

endmodule

// File: rtl/fir_rate_bank.sv
module fir_rate_bank
   import fir_rate_bank_pkg::*;
#(
   parameter int DW          = 12,
   parameter int CW          = 8,
   parameter int TAPS        = 5,
   parameter bit FOLD        = 1'b1,
   parameter int DIV_MID     = 8,
   parameter int DIV_SLOW    = 32,
   parameter int SYNC_STAGES = 2,
   localparam int OW         = DW + CW + $clog2(TAPS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic signed [DW-1:0] din,
   input  logic [1:0]           sw,
   output logic signed [OW-1:0] dout
);

   if (DIV_SLOW % DIV_MID != 0) begin : g_bad_ratio
      $error("DIV_SLOW must be a multiple of DIV_MID");
   end
   if (DW < 2 || CW < 2) begin : g_bad_width
      $error("DW and CW must be at least 2");
   end

   logic                 stb_mid;
   logic                 stb_slow;
   logic [NPATH-1:0]     path_en;
   logic signed [OW-1:0] path_y [NPATH];
   logic [1:0]           sel_q;
   path_e                sel_path;
   logic signed [OW-1:0] dout_q;

   fir_rate_bank_strobe #(
      .DIV_MID  (DIV_MID),
      .DIV_SLOW (DIV_SLOW)
   ) strobe_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb_mid  (stb_mid),
      .stb_slow (stb_slow)
   );

   assign path_en = {stb_slow, stb_mid, 1'b1};

   for (genvar p = 0; p < NPATH; p++) begin : g_path
      fir_rate_bank_path #(
         .DW   (DW),
         .CW   (CW),
         .TAPS (TAPS),
         .FOLD (FOLD),
         .OW   (OW)
      ) path_i (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (path_en[p]),
         .x     (din),
         .y     (path_y[p])
      );
   end

   fir_rate_bank_sync #(
      .W      (2),
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sw),
      .q     (sel_q)
   );

   always_comb sel_path = decode_sel(sel_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dout_q <= '0;
      else        dout_q <= path_y[sel_path];
   end

   assign dout = dout_q;

endmodule

// File: rtl/fir_rate_bank_chk.sv
module fir_rate_bank_chk #(
   parameter int OW       = 23,
   parameter int DIV_MID  = 8,
   parameter int DIV_SLOW = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 stb_mid,
   input logic                 stb_slow,
   input logic signed [OW-1:0] y_mid,
   input logic signed [OW-1:0] y_slow,
   input logic [1:0]           sel_q,
   input logic signed [OW-1:0] dout
);

   int gap_mid;
   int gap_slow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_mid  <= 0;
         gap_slow <= 0;
      end else begin
         gap_mid  <= stb_mid  ? 0 : gap_mid + 1;
         gap_slow <= stb_slow ? 0 : gap_slow + 1;
      end
   end

   a_r1_reset_clear: assert property (@(posedge clk) !rst_n |-> dout == '0);

   a_r3_mid_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      stb_mid |-> gap_mid == DIV_MID - 1);

   a_r3_mid_no_late: assert property (@(posedge clk) disable iff (!rst_n)
      gap_mid < DIV_MID);

   a_r4_slow_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      stb_slow |-> gap_slow == DIV_SLOW - 1);

   a_r4_slow_on_mid: assert property (@(posedge clk) disable iff (!rst_n)
      stb_slow |-> stb_mid);

   a_r6_mid_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !stb_mid |=> $stable(y_mid));

   a_r6_slow_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !stb_slow |=> $stable(y_slow));

   a_r5_slow_out_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q == 2'b10 && $past(sel_q) == 2'b10 && !$past(stb_slow)) |=> $stable(dout));

endmodule

bind fir_rate_bank fir_rate_bank_chk #(
   .OW       (OW),
   .DIV_MID  (DIV_MID),
   .DIV_SLOW (DIV_SLOW)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .stb_mid  (stb_mid),
   .stb_slow (stb_slow),
   .y_mid    (path_y[1]),
   .y_slow   (path_y[2]),
   .sel_q    (sel_q),
   .dout     (dout)
);

// File: tb/fir_rate_bank_tb_top.sv
`timescale 1ns/1ps
module fir_rate_bank_tb_top;

   localparam int DW       = 12;
   localparam int CW       = 8;
   localparam int TAPS     = 5;
   localparam int DIV_MID  = 8;
   localparam int DIV_SLOW = 32;
   localparam int OW       = DW + CW + $clog2(TAPS);

   logic                 clk   = 1'b0;
   logic                 rst_n = 1'b1;
   logic signed [DW-1:0] din   = '0;
   logic [1:0]           sw    = 2'b00;
   logic signed [OW-1:0] dout;

   always #2.5 clk = ~clk;

   fir_rate_bank #(
      .DW (DW), .CW (CW), .TAPS (TAPS), .FOLD (1'b1),
      .DIV_MID (DIV_MID), .DIV_SLOW (DIV_SLOW), .SYNC_STAGES (2)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .din (din), .sw (sw), .dout (dout)
   );

   int n_chk = 0;
   int n_bad = 0;

   // Arithmetic model built from the requirements.
   int    hf [TAPS];
   int    hm [TAPS];
   int    hs [TAPS];
   int    yf, ym, ys;
   int    s1, s2;
   int    k;
   int    exp_dout;
   string exp_tag;
   logic [15:0] lfsr = 16'hACE1;

   function automatic int cf(input int i);
      return ((i < TAPS - 1 - i) ? i : TAPS - 1 - i) + 1;   // R8 weights
   endfunction

   function automatic int fir_of(input int h [TAPS]);
      int s = 0;
      for (int i = 0; i < TAPS; i++) s += cf(i) * h[i];
      return s;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (edge %0d)", tag, act, exp, k);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < TAPS; i++) begin
         hf[i] = 0; hm[i] = 0; hs[i] = 0;
      end
      yf = 0; ym = 0; ys = 0; s1 = 0; s2 = 0; k = 0;
      exp_dout = 0; exp_tag = "R1";
   endtask

   task automatic model_step(input int x, input int code);
      int nd;
      k++;
      case (s2)
         1:       begin nd = ym; exp_tag = "R3,R5,R6";    end
         2:       begin nd = ys; exp_tag = "R4,R5,R6,R7"; end
         default: begin nd = yf; exp_tag = "R2,R5,R8";    end
      endcase
      s2 = s1;
      s1 = code;
      for (int i = TAPS - 1; i > 0; i--) hf[i] = hf[i-1];
      hf[0] = x; yf = fir_of(hf);
      if (k % DIV_MID == 0) begin
         for (int i = TAPS - 1; i > 0; i--) hm[i] = hm[i-1];
         hm[0] = x; ym = fir_of(hm);
      end
      if (k % DIV_SLOW == 0) begin
         for (int i = TAPS - 1; i > 0; i--) hs[i] = hs[i-1];
         hs[0] = x; ys = fir_of(hs);
      end
      exp_dout = nd;
   endtask

   // One clock: check the previous result, apply new inputs, advance.
   task automatic cycle(input int x, input int code);
      @(negedge clk);
      check(exp_tag, int'(dout), exp_dout);
      din = x[DW-1:0];
      sw  = code[1:0];
      model_step(x, code);
      @(posedge clk);
   endtask

   function automatic int pattern(input int pat, input int t);
      case (pat)
         0:       return (t == 3) ? 1000 : 0;             // impulse
         1:       return (t >= 5) ? 700 : -300;           // step
         2:       return (t % 2 == 1) ? 1500 : -1500;     // fast Nyquist tone
         default: return int'($signed(lfsr[DW-1:0]));      // pseudo-random
      endcase
   endfunction

   task automatic lfsr_step();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      #0.5;
      check("R1", int'(dout), 0);
      model_reset();
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R1", int'(dout), 0);
      end
      @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   initial begin
      #1 rst_n = 1'b0;
      model_reset();
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check("R1", int'(dout), 0);
      end
      @(posedge clk);
      #1 rst_n = 1'b1;

      // Sweep every switch code against every input pattern.
      for (int code = 0; code < 4; code++) begin
         for (int pat = 0; pat < 4; pat++) begin
            for (int t = 0; t < 160; t++) begin
               lfsr_step();
               cycle(pattern(pat, t), code);
            end
         end
      end

      // R5: switches change every three clocks while random data flows.
      for (int t = 0; t < 480; t++) begin
         lfsr_step();
         cycle(pattern(3, t), (t / 3) % 4);
      end

      // R1: reset in the middle of activity, then resume on the slow copy.
      do_reset();
      for (int t = 0; t < 200; t++) begin
         lfsr_step();
         cycle(pattern(2, t), 2);
      end
      for (int t = 0; t < 100; t++) begin
         lfsr_step();
         cycle(pattern(3, t), 1);
      end
      @(negedge clk);
      check(exp_tag, int'(dout), exp_dout);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog: actual still running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule